// File: doc/BRIEF.md
# DRAM Cycle Type Decoder

This block sits beside an asynchronous DRAM interface and watches the row strobe, column strobe, write enable and address lines. It samples them on every clock and names each memory cycle it sees: read, early write, read-modify-write, write with indeterminate read data, row-strobe-only refresh, column-before-row refresh, hidden refresh, or a column-before-row refresh attempted with write enable low. Each access cycle inside a row is reported on its own, with its position in the row, so page-mode bursts show up as a sequence of reports.

All timing is measured in clock samples. It is the number of clocks between the samples in which two line changes are first seen. The same counters also drive four sticky flags for minimum-time violations: row-strobe precharge, row-strobe low width, column-strobe low width and column-strobe precharge within a row. A bus monitor or a protocol checker in a larger verification or debug fabric uses the decoder. It reads the one-clock report strobe and the flags, and clears the flags when it has read them.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is held low at a clock edge, and after it, before any line change: cyc_valid is 0, cyc_type is 0, page_idx is 0 and err_flags is 0.
- R2: A column-strobe pulse inside a row-strobe-low period, with write enable high throughout, is reported as type 0 (read). The report is a single-clock cyc_valid that rises on the second rising clock edge after the column-strobe rise is applied.
- R3: If write enable is low in the sample where the column strobe is first seen low, that column cycle is reported as type 1 (early write).
- R4: A write enable fall while the column strobe is low gives type 2 (read-modify-write) only if all three hold, in samples: at least CWD (5) since the column strobe fell, at least AWD (7) since the last address change, and at least RWD (11) since the row strobe fell. Otherwise that column cycle is type 6 (indeterminate).
- R5: A row-strobe-low period with no column-strobe fall is reported as type 3 when the row strobe rises, with page_idx 0.
- R6: If the column strobe is low when the row strobe falls, and that low level was not carried over from an access, the period is type 4 (column-before-row refresh), reported at the row-strobe rise with page_idx 0. If write enable is low in the row-strobe fall sample of any refresh of this kind, the type is 7 instead.
- R7: An access whose column strobe is still low at the row-strobe rise is reported at that rise. If the next row-strobe fall finds that same column strobe still low, the period is type 5 (hidden refresh).
- R8: Each column-strobe pulse within one row-strobe-low period is reported on its own. page_idx gives its 1-based position and restarts at each row-strobe fall.
- R9: err_flags bit 0 sets when the row strobe falls after fewer than RP_MIN (5) samples high. Bit 1 sets when it rises after fewer than RAS_MIN (8) samples low.
- R10: err_flags bit 2 sets when the column strobe rises after fewer than CAS_MIN (2) samples low. Bit 3 sets when it falls during row-strobe low after fewer than CP_MIN (2) samples high.
- R11: Error flags stay set until err_clr is sampled high. A violation detected in the same clock as a clear still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed address lines |
| err_clr | input | 1 | Clears the sticky error flags |
| cyc_valid | output | 1 | One-clock report strobe |
| cyc_type | output | 3 | Cycle type code of the report |
| page_idx | output | PAGE_W | Position of the column cycle in its row, 0 for refresh |
| err_flags | output | 4 | Sticky minimum-time violation flags |

## Verification
The hardest case to reach is a late write enable edge that meets two of the three read-modify-write windows but misses the third by a single sample. Random stimulus seldom lands on that boundary. Directed sequences place the address change, column fall and write fall so that each distance sits exactly at its threshold, and then one sample short. Random page-mode rows with write edges at random offsets then fill the space between those points. Hidden refresh needs a read whose column strobe is held across a full row precharge, and it is built as a directed sequence.

// File: rtl/dcd_pkg.sv
// Package: shared codes for the DRAM cycle type decoder.
// Assumes: line index order RAS, CAS, WE in the sampled line vector.
package dcd_pkg;

    typedef enum logic [2:0] {
        CT_READ       = 3'd0,
        CT_EARLY_WR   = 3'd1,
        CT_RMW        = 3'd2,
        CT_RAS_ONLY   = 3'd3,
        CT_CBR        = 3'd4,
        CT_HIDDEN     = 3'd5,
        CT_INDET      = 3'd6,
        CT_REF_WE_LOW = 3'd7
    } cyc_type_t;

    localparam int LN_RAS  = 0;
    localparam int LN_CAS  = 1;
    localparam int LN_WE   = 2;
    localparam int N_LINES = 3;

    localparam int ERR_RP  = 0;
    localparam int ERR_RAS = 1;
    localparam int ERR_CAS = 2;
    localparam int ERR_CP  = 3;
    localparam int ERR_N   = 4;

    localparam int TM_RAS_LOW  = 0;
    localparam int TM_RAS_HIGH = 1;
    localparam int TM_CAS_LOW  = 2;
    localparam int TM_CAS_HIGH = 3;
    localparam int TM_ADDR     = 4;
    localparam int N_TIMERS    = 5;

endpackage

// File: rtl/dcd_line_sampler.sv
// Module: dcd_line_sampler
// Registers the strobe lines and the address twice. The current sample and
// the previous sample come out so that edges can be found downstream.
// Assumes: strobes are inactive high, so both stages reset to 1.
module dcd_line_sampler #(
    parameter int N_LINES = 3,
    parameter int ADDR_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_LINES-1:0] cur,
    output logic [N_LINES-1:0] prev,
    output logic               addr_chg
);

    logic [ADDR_W-1:0] addr_cur;
    logic [ADDR_W-1:0] addr_prev;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // Two-stage sample of one strobe line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur[i]  <= 1'b1;
                prev[i] <= 1'b1;
            end else begin
                cur[i]  <= lines[i];
                prev[i] <= cur[i];
            end
        end
    end

    // Two-stage sample of the address bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cur  <= '0;
            addr_prev <= '0;
        end else begin
            addr_cur  <= addr;
            addr_prev <= addr_cur;
        end
    end

    // Any differing address bit marks a change between the two samples.
    always_comb addr_chg = |(addr_cur ^ addr_prev);

endmodule

// File: rtl/dcd_interval_timer.sv
// Module: dcd_interval_timer
// Counts samples since the last restart pulse and saturates at all ones.
// In the cycle where a later event is seen, the count is the number of
// samples between the two events.
// Assumes: after reset the last event lies far in the past (count saturated).
module dcd_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Restart at one, otherwise count up to the saturation value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_MAX;
        end else if (restart) begin
            count <= CNT_ONE;
        end else if (count != CNT_MAX) begin
            count <= count + CNT_ONE;
        end
    end

endmodule

// File: rtl/dcd_classifier.sv
// Module: dcd_classifier
// Follows each row-strobe-low period and names the column cycles and
// refreshes in it. Emits one-clock reports with a type and page position.
// Assumes: edges and timers come from the same sample stage, so all
// distances are counted in samples.
module dcd_classifier
    import dcd_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PAGE_W = 4,
    parameter int CWD    = 5,
    parameter int AWD    = 7,
    parameter int RWD    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cas,
    input  logic              s_we,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              we_fall,
    input  logic [CNT_W-1:0]  t_ras,
    input  logic [CNT_W-1:0]  t_cas,
    input  logic [CNT_W-1:0]  t_addr,
    output logic              rep_valid,
    output cyc_type_t         rep_type,
    output logic [PAGE_W-1:0] rep_page
);

    localparam logic [CNT_W-1:0]  CWD_C    = CNT_W'(CWD);
    localparam logic [CNT_W-1:0]  AWD_C    = CNT_W'(AWD);
    localparam logic [CNT_W-1:0]  RWD_C    = CNT_W'(RWD);
    localparam logic [PAGE_W-1:0] PAGE_MAX = '1;

    typedef enum logic [1:0] {M_IDLE, M_ACCESS, M_REFRESH} mode_t;
    typedef enum logic [1:0] {W_NONE, W_EARLY, W_LATE_OK, W_LATE_BAD} wr_t;

    mode_t             mode;
    wr_t               wr_kind;
    logic              cas_act;
    logic              cas_held;
    logic [PAGE_W-1:0] page_cnt;
    cyc_type_t         ref_type;
    logic              window_ok;

    // Map the recorded write behaviour of a column cycle to its report code.
    function automatic cyc_type_t wr_code(input wr_t w);
        case (w)
            W_EARLY:    return CT_EARLY_WR;
            W_LATE_OK:  return CT_RMW;
            W_LATE_BAD: return CT_INDET;
            default:    return CT_READ;
        endcase
    endfunction

    // A late write edge qualifies only if all three distances are long enough.
    always_comb window_ok = (t_cas >= CWD_C) && (t_addr >= AWD_C) && (t_ras >= RWD_C);

    // Row-period mode, column-cycle tracking and report generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= M_IDLE;
            wr_kind   <= W_NONE;
            cas_act   <= 1'b0;
            cas_held  <= 1'b0;
            page_cnt  <= '0;
            ref_type  <= CT_CBR;
            rep_valid <= 1'b0;
            rep_type  <= CT_READ;
            rep_page  <= '0;
        end else begin
            rep_valid <= 1'b0;
            if (cas_rise) begin
                cas_held <= 1'b0;
            end
            if (ras_fall) begin
                page_cnt <= '0;
                wr_kind  <= W_NONE;
                cas_act  <= 1'b0;
                if (!s_cas) begin
                    mode <= M_REFRESH;
                    if (!s_we) begin
                        ref_type <= CT_REF_WE_LOW;
                    end else if (cas_held) begin
                        ref_type <= CT_HIDDEN;
                    end else begin
                        ref_type <= CT_CBR;
                    end
                end else begin
                    mode <= M_ACCESS;
                end
            end else if (ras_rise) begin
                if (mode == M_ACCESS) begin
                    if (cas_act) begin
                        rep_valid <= 1'b1;
                        rep_type  <= wr_code(wr_kind);
                        rep_page  <= page_cnt;
                        if (!s_cas) begin
                            cas_held <= 1'b1;
                        end
                    end else if (page_cnt == '0) begin
                        rep_valid <= 1'b1;
                        rep_type  <= CT_RAS_ONLY;
                        rep_page  <= '0;
                    end
                end else if (mode == M_REFRESH) begin
                    rep_valid <= 1'b1;
                    rep_type  <= ref_type;
                    rep_page  <= '0;
                end
                mode    <= M_IDLE;
                cas_act <= 1'b0;
            end else if (mode == M_ACCESS) begin
                if (cas_fall) begin
                    cas_act <= 1'b1;
                    wr_kind <= s_we ? W_NONE : W_EARLY;
                    if (page_cnt != PAGE_MAX) begin
                        page_cnt <= page_cnt + 1'b1;
                    end
                end else if (cas_act && cas_rise) begin
                    rep_valid <= 1'b1;
                    rep_type  <= wr_code(wr_kind);
                    rep_page  <= page_cnt;
                    cas_act   <= 1'b0;
                end else if (cas_act && we_fall && (wr_kind == W_NONE)) begin
                    wr_kind <= window_ok ? W_LATE_OK : W_LATE_BAD;
                end
            end
        end
    end

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !rep_valid);

    // R5
    ras_only_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_type == CT_RAS_ONLY) |-> (rep_page == '0));

    // R8
    access_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && (rep_type inside {CT_READ, CT_EARLY_WR, CT_RMW, CT_INDET}))
        |-> (rep_page != '0));

    // R6
    cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !s_cas && !s_we) |=> (ref_type == CT_REF_WE_LOW));

endmodule

// File: rtl/dcd_min_time_check.sv
// Module: dcd_min_time_check
// Compares strobe widths and precharge times with their minimums at each
// closing edge and keeps a sticky flag for each kind of violation.
// Assumes: timers restart on the opposite edge of the same line.
module dcd_min_time_check
    import dcd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RP_MIN  = 5,
    parameter int RAS_MIN = 8,
    parameter int CAS_MIN = 2,
    parameter int CP_MIN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_ras,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic             cas_fall,
    input  logic             cas_rise,
    input  logic [CNT_W-1:0] t_ras_low,
    input  logic [CNT_W-1:0] t_ras_high,
    input  logic [CNT_W-1:0] t_cas_low,
    input  logic [CNT_W-1:0] t_cas_high,
    input  logic             err_clr,
    output logic [ERR_N-1:0] err_q
);

    localparam logic [CNT_W-1:0] RP_C  = CNT_W'(RP_MIN);
    localparam logic [CNT_W-1:0] RAS_C = CNT_W'(RAS_MIN);
    localparam logic [CNT_W-1:0] CAS_C = CNT_W'(CAS_MIN);
    localparam logic [CNT_W-1:0] CP_C  = CNT_W'(CP_MIN);

    logic [ERR_N-1:0] viol;

    // Detect each violation at the edge that closes the measured interval.
    always_comb begin
        viol          = '0;
        viol[ERR_RP]  = ras_fall && (t_ras_high < RP_C);
        viol[ERR_RAS] = ras_rise && (t_ras_low < RAS_C);
        viol[ERR_CAS] = cas_rise && (t_cas_low < CAS_C);
        viol[ERR_CP]  = cas_fall && !s_ras && !ras_fall && (t_cas_high < CP_C);
    end

    // Sticky flags: clear first, then a new violation sets its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_clr ? '0 : err_q) | viol;
        end
    end

    for (genvar i = 0; i < ERR_N; i++) begin : g_sticky
        // R11
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !err_clr) |=> err_q[i]);
    end

    // R9
    rp_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[ERR_RP]) |-> $past(ras_fall));

    // R10
    cas_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[ERR_CAS]) |-> $past(cas_rise));

endmodule

// File: rtl/dram_cycle_decoder.sv
// Module: dram_cycle_decoder (top)
// Samples DRAM control strobes and address, finds edges, measures the
// distances between them and classifies every cycle. It also keeps sticky
// minimum-time violation flags.
// Assumes: strobes are stable for at least one clock between changes.
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PAGE_W  = 4,
    parameter int CNT_W   = 8,
    parameter int CWD     = 5,
    parameter int AWD     = 7,
    parameter int RWD     = 11,
    parameter int RP_MIN  = 5,
    parameter int RAS_MIN = 8,
    parameter int CAS_MIN = 2,
    parameter int CP_MIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              err_clr,
    output logic              cyc_valid,
    output logic [2:0]        cyc_type,
    output logic [PAGE_W-1:0] page_idx,
    output logic [3:0]        err_flags
);

    logic [N_LINES-1:0] lines_in;
    logic [N_LINES-1:0] s_line;
    logic [N_LINES-1:0] p_line;
    logic               addr_chg;
    logic               ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [N_TIMERS-1:0] t_restart;
    logic [CNT_W-1:0]    t_val [N_TIMERS];
    cyc_type_t           rep_type;
    logic [ERR_N-1:0]    err_q;

    // Pack the strobes in the order the package defines.
    always_comb begin
        lines_in         = '1;
        lines_in[LN_RAS] = ras_n;
        lines_in[LN_CAS] = cas_n;
        lines_in[LN_WE]  = we_n;
    end

    dcd_line_sampler #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (lines_in),
        .addr     (addr),
        .cur      (s_line),
        .prev     (p_line),
        .addr_chg (addr_chg)
    );

    // Edge pulses from the current and previous samples.
    always_comb begin
        ras_fall = p_line[LN_RAS] && !s_line[LN_RAS];
        ras_rise = !p_line[LN_RAS] && s_line[LN_RAS];
        cas_fall = p_line[LN_CAS] && !s_line[LN_CAS];
        cas_rise = !p_line[LN_CAS] && s_line[LN_CAS];
        we_fall  = p_line[LN_WE] && !s_line[LN_WE];
    end

    // Restart sources of the interval timers.
    always_comb begin
        t_restart              = '0;
        t_restart[TM_RAS_LOW]  = ras_fall;
        t_restart[TM_RAS_HIGH] = ras_rise;
        t_restart[TM_CAS_LOW]  = cas_fall;
        t_restart[TM_CAS_HIGH] = cas_rise;
        t_restart[TM_ADDR]     = addr_chg;
    end

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
        dcd_interval_timer #(.CNT_W(CNT_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (t_restart[i]),
            .count   (t_val[i])
        );
    end

    dcd_classifier #(
        .CNT_W(CNT_W), .PAGE_W(PAGE_W), .CWD(CWD), .AWD(AWD), .RWD(RWD)
    ) u_classifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_cas     (s_line[LN_CAS]),
        .s_we      (s_line[LN_WE]),
        .ras_fall  (ras_fall),
        .ras_rise  (ras_rise),
        .cas_fall  (cas_fall),
        .cas_rise  (cas_rise),
        .we_fall   (we_fall),
        .t_ras     (t_val[TM_RAS_LOW]),
        .t_cas     (t_val[TM_CAS_LOW]),
        .t_addr    (t_val[TM_ADDR]),
        .rep_valid (cyc_valid),
        .rep_type  (rep_type),
        .rep_page  (page_idx)
    );

    dcd_min_time_check #(
        .CNT_W(CNT_W), .RP_MIN(RP_MIN), .RAS_MIN(RAS_MIN),
        .CAS_MIN(CAS_MIN), .CP_MIN(CP_MIN)
    ) u_min_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_ras      (s_line[LN_RAS]),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .cas_fall   (cas_fall),
        .cas_rise   (cas_rise),
        .t_ras_low  (t_val[TM_RAS_LOW]),
        .t_ras_high (t_val[TM_RAS_HIGH]),
        .t_cas_low  (t_val[TM_CAS_LOW]),
        .t_cas_high (t_val[TM_CAS_HIGH]),
        .err_clr    (err_clr),
        .err_q      (err_q)
    );

    // Drive the output ports.
    always_comb begin
        cyc_type  = rep_type;
        err_flags = err_q;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!cyc_valid && err_flags == 4'd0));

endmodule

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;

    localparam int CWD = 5, AWD = 7, RWD = 11;
    localparam int RP_MIN = 5, RAS_MIN = 8, CAS_MIN = 2, CP_MIN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_i = 1'b1, cas_i = 1'b1, we_i = 1'b1;
    logic [10:0] addr_i = '0;
    logic        clr_i = 1'b0;
    logic        cyc_valid;
    logic [2:0]  cyc_type;
    logic [3:0]  page_idx;
    logic [3:0]  err_flags;

    int checks = 0;
    int fails  = 0;
    int now    = 0;
    int ev_t[$];
    int ev_p[$];
    int ex_t[$];
    int ex_p[$];

    always #4 clk = ~clk;

    dram_cycle_decoder u_dram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_i), .cas_n(cas_i), .we_n(we_i),
        .addr(addr_i), .err_clr(clr_i), .cyc_valid(cyc_valid),
        .cyc_type(cyc_type), .page_idx(page_idx), .err_flags(err_flags)
    );

    // Record every report seen at the falling edge.
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            ev_t.push_back(int'(cyc_type));
            ev_p.push_back(int'(page_idx));
        end
    end

    function automatic int late_code(input int dc, input int da, input int dr);
        return (dc >= CWD && da >= AWD && dr >= RWD) ? 2 : 6;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        now += n;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_scn();
        ev_t.delete(); ev_p.delete(); ex_t.delete(); ex_p.delete();
    endtask

    task automatic expect_ev(input int t, input int p);
        ex_t.push_back(t);
        ex_p.push_back(p);
    endtask

    task automatic end_scn(input string req);
        chk(req, "report count", ev_t.size(), ex_t.size());
        for (int i = 0; i < ex_t.size(); i++) begin
            chk(req, "report type", (i < ev_t.size()) ? ev_t[i] : -1, ex_t[i]);
            chk(req, "report page", (i < ev_p.size()) ? ev_p[i] : -1, ex_p[i]);
        end
    endtask

    task automatic clear_err();
        clr_i = 1'b1; tick(1); clr_i = 1'b0; tick(2);
    endtask

    // One random page-mode row with random write behaviour per column cycle.
    task automatic rand_row();
        int n, tr, ta, tc, mode, d;
        n = 1 + int'($urandom % 3);
        start_scn();
        addr_i = addr_i + 11'(1 + $urandom % 100);
        ras_i = 1'b0; tr = now; ta = now;
        tick(1 + int'($urandom % 4));
        for (int k = 0; k < n; k++) begin
            if ($urandom % 2 == 1) begin
                addr_i = addr_i + 11'(1 + $urandom % 50); ta = now;
                tick(1 + int'($urandom % 3));
            end
            mode = int'($urandom % 3);
            if (mode == 1) we_i = 1'b0;
            cas_i = 1'b0; tc = now;
            if (mode == 2) begin
                d = 1 + int'($urandom % 9);
                tick(d);
                we_i = 1'b0;
                expect_ev(late_code(now - tc, now - ta, now - tr), k + 1);
                tick(1 + int'($urandom % 2));
            end else begin
                expect_ev(mode, k + 1);
                tick(CAS_MIN + int'($urandom % 3));
            end
            cas_i = 1'b1; we_i = 1'b1;
            tick(CP_MIN + int'($urandom % 3));
        end
        if (now - tr < RAS_MIN + 1) tick(RAS_MIN + 1 - (now - tr));
        ras_i = 1'b1;
        tick(RP_MIN + 1 + int'($urandom % 3));
        end_scn("R8 random row");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        // R1: outputs quiet during and after reset
        chk("R1", "valid in reset", int'(cyc_valid), 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1", "valid", int'(cyc_valid), 0);
        chk("R1", "type", int'(cyc_type), 0);
        chk("R1", "page", int'(page_idx), 0);
        chk("R1", "err", int'(err_flags), 0);
        tick(6);

        // R2: read with exact report latency
        start_scn();
        ras_i = 0; tick(2); cas_i = 0; tick(3); cas_i = 1;
        tick(1);
        chk("R2", "valid one clock early", int'(cyc_valid), 0);
        tick(1);
        chk("R2", "valid on time", int'(cyc_valid), 1);
        chk("R2", "type", int'(cyc_type), 0);
        tick(1);
        chk("R2", "valid after pulse", int'(cyc_valid), 0);
        tick(3); ras_i = 1; tick(6);
        expect_ev(0, 1); end_scn("R2");

        // R3: early write
        start_scn();
        ras_i = 0; tick(2); we_i = 0; cas_i = 0; tick(3); cas_i = 1; we_i = 1;
        tick(4); ras_i = 1; tick(6);
        expect_ev(1, 1); end_scn("R3");

        // R4: all windows exactly met -> read-modify-write
        start_scn();
        addr_i = 11'h100; ras_i = 0; tick(4); addr_i = 11'h005; tick(2);
        cas_i = 0; tick(5); we_i = 0; tick(2); cas_i = 1; we_i = 1; tick(2);
        ras_i = 1; tick(6);
        expect_ev(2, 1); end_scn("R4 boundary met");

        // R4: row window one sample short -> indeterminate
        start_scn();
        addr_i = 11'h200; tick(1); ras_i = 0; tick(3); addr_i = 11'h006; tick(2);
        cas_i = 0; tick(5); we_i = 0; tick(2); cas_i = 1; we_i = 1; tick(2);
        ras_i = 1; tick(6);
        expect_ev(6, 1); end_scn("R4 row window short");

        // R4: column window short -> indeterminate
        start_scn();
        addr_i = 11'h300; ras_i = 0; tick(10); cas_i = 0; tick(1); we_i = 0;
        tick(2); cas_i = 1; we_i = 1; tick(2); ras_i = 1; tick(6);
        expect_ev(6, 1); end_scn("R4 column window short");

        // R5: row-strobe-only refresh
        start_scn();
        ras_i = 0; tick(9); ras_i = 1; tick(6);
        expect_ev(3, 0); end_scn("R5");

        // R6: column-before-row refresh
        start_scn();
        cas_i = 0; tick(2); ras_i = 0; tick(9); ras_i = 1; tick(1); cas_i = 1; tick(6);
        expect_ev(4, 0); end_scn("R6");

        // R6: column-before-row with write enable low
        start_scn();
        cas_i = 0; we_i = 0; tick(2); ras_i = 0; tick(2); we_i = 1; tick(7);
        ras_i = 1; tick(1); cas_i = 1; tick(6);
        expect_ev(7, 0); end_scn("R6 we low");

        // R7: read held across precharge, then hidden refresh
        start_scn();
        ras_i = 0; tick(2); cas_i = 0; tick(7); ras_i = 1; tick(6);
        ras_i = 0; tick(9); ras_i = 1; tick(2); cas_i = 1; tick(6);
        expect_ev(0, 1); expect_ev(5, 0); end_scn("R7");
        chk("R7", "no timing flags", int'(err_flags), 0);

        // R8: three-cycle page burst with mixed types
        start_scn();
        ras_i = 0; tick(2);
        cas_i = 0; tick(2); cas_i = 1; tick(2);
        we_i = 0; cas_i = 0; tick(2); cas_i = 1; we_i = 1; tick(2);
        cas_i = 0; tick(2); cas_i = 1; tick(2);
        ras_i = 1; tick(6);
        expect_ev(0, 1); expect_ev(1, 2); expect_ev(0, 3); end_scn("R8");
        chk("R8", "no timing flags", int'(err_flags), 0);

        // R9: short row-strobe low
        ras_i = 0; tick(3); ras_i = 1; tick(6);
        chk("R9", "ras low short flag", int'(err_flags), 4'b0010);
        // R11: flag survives a clean cycle, then clears
        ras_i = 0; tick(9); ras_i = 1; tick(6);
        chk("R11", "sticky", int'(err_flags), 4'b0010);
        clear_err();
        chk("R11", "cleared", int'(err_flags), 0);

        // R9: short precharge
        ras_i = 0; tick(9); ras_i = 1; tick(2); ras_i = 0; tick(9); ras_i = 1; tick(6);
        chk("R9", "precharge short flag", int'(err_flags), 4'b0001);
        clear_err();

        // R10: short column low
        ras_i = 0; tick(2); cas_i = 0; tick(1); cas_i = 1; tick(7); ras_i = 1; tick(6);
        chk("R10", "cas low short flag", int'(err_flags), 4'b0100);
        clear_err();

        // R10: short column precharge inside a row
        ras_i = 0; tick(2); cas_i = 0; tick(2); cas_i = 1; tick(1); cas_i = 0; tick(2);
        cas_i = 1; tick(2); ras_i = 1; tick(6);
        chk("R10", "cas precharge short flag", int'(err_flags), 4'b1000);

        // R11: violation in the same clock as clear still sets its flag
        ras_i = 0; tick(3); ras_i = 1; tick(1); clr_i = 1; tick(1); clr_i = 0; tick(3);
        chk("R11", "set beats clear", int'(err_flags), 4'b0010);
        clear_err();

        // R2 R3 R4 R8: random page-mode rows
        for (int r = 0; r < 60; r++) rand_row();
        chk("R8", "random rows flag-free", int'(err_flags), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", now);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule